// File: doc/BRIEF.md
# Masked Wake Request Generator

This block turns a bank of eight logic-fabric outputs into one wake-up / interrupt request line. A per-output enable mask chooses which fabric outputs may raise the request; the enabled outputs are OR-ed into a raw request. That raw request then reaches the output by one of three routes. It can go straight through. It can go through a glitch filter clocked by one of three incoming filter clocks. Or it can be held in a sticky flag that is sampled on the fabric clock and cleared by software.

The filter and the sticky flag are meant to be used one at a time. If the sticky flag is enabled, it always samples the unfiltered raw request, whatever filter length is programmed. The filter removes pulses that are shorter than the programmed number of filter-clock periods. The pulses it targets come from the uneven delays through the fabric. The clear input is sampled on the fabric clock only, so clearing and reading back the flag never need a bus clock.

Top module: `wake_req_gen`

## Requirements
- R1: The raw request is high exactly when some bit n has both `intMask[n]` and `fabOut[n]` high; masked-off outputs have no effect on `wakeReq`.
- R2: After `rstN` is low, the filter output and the sticky flag are 0, so with `filtMode` = 0 (bypass) and an all-zero mask, `wakeReq` is 0.
- R3: With `latchEn` = 0 and `filtMode` = 0, `wakeReq` equals the raw request combinationally, with no clock edge needed.
- R4: With `latchEn` = 0 and `filtMode` = N (1, 2 or 3), `wakeReq` takes a new level only at the Nth consecutive rising filter-clock edge at which the raw request differs from the current output. A sample that agrees with the output restarts the count.
- R5: `filtClkSel` picks the filter clock: 0 selects `filtClkLp`, 1 selects `filtClkFast`, 2 or 3 selects `filtClkAlt`. Edges on the unselected clocks do not move the filter.
- R6: With `latchEn` = 1, a rising `clk` edge at which the raw request is high sets the sticky flag. The flag, which `wakeReq` shows, then stays 1 after the raw request falls.
- R7: With `latchEn` = 1, `latchClr` high at a rising `clk` edge clears the flag when the raw request is low. If the raw request is high at that same edge, the flag stays set.
- R8: In latch mode the flag samples the unfiltered raw request even when `filtMode` is non-zero, so it sets without any filter-clock edge.
- R9: With `latchEn` = 0, `wakeReq` has no stickiness. A rising `clk` edge with `latchEn` = 0 empties the sticky flag, so re-enabling latch mode with the raw request low gives `wakeReq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; samples the sticky flag and the clear |
| rstN | input | 1 | Active-low asynchronous reset for both clock domains |
| fabOut | input | 8 | Logic-fabric outputs |
| intMask | input | 8 | Per-output request enable, bit n for output n |
| filtMode | input | 2 | 0 bypass, 1..3 filter length in filter-clock periods |
| filtClkSel | input | 2 | Filter clock choice: 0 low-power, 1 fast, 2/3 alternate |
| filtClkLp | input | 1 | Low-power (about 1 MHz) filter clock |
| filtClkFast | input | 1 | Fast (about 12 MHz) filter clock |
| filtClkAlt | input | 1 | Alternate filter clock |
| latchEn | input | 1 | Selects the sticky-flag route |
| latchClr | input | 1 | Software clear of the sticky flag, sampled on `clk` |
| wakeReq | output | 1 | Wake-up / interrupt request |

## Verification
The filter is exercised with a steady change of level and with a one-sample glitch placed between disagreeing samples, at each of the three lengths. Only the glitch case tells a "consecutive" count apart from a plain count of disagreements. Each length uses a different clock selection, and edges are also pulsed on clocks that are not selected, which shows that the selection really gates the filter. The mask is tried with all outputs enabled, with none enabled, and with a single bit enabled against both matching and complementary fabric patterns. The sticky flag is tried with a single-cycle raw pulse, with a plain clear, with a clear that coincides with a raw-high edge, and with a non-zero filter length, which shows that the flag samples the unfiltered request.

// File: rtl/wake_req_pkg.sv
package wake_req_pkg;
  localparam int unsigned LenW = 2;
  localparam int unsigned SelW = 2;

  typedef struct packed {
    logic            bypass;
    logic            latchMode;
    logic            clrStrobe;
    logic [LenW-1:0] filtLen;
    logic [SelW-1:0] clkPick;
  } wakeCtrlT;
endpackage

// File: rtl/wake_req_ctrl.sv
module wake_req_ctrl
  import wake_req_pkg::*;
(
  input  logic [LenW-1:0] filtMode,
  input  logic [SelW-1:0] filtClkSel,
  input  logic            latchEn,
  input  logic            latchClr,
  output wakeCtrlT        ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.bypass    = (filtMode == '0);
    ctrl.filtLen   = filtMode;
    ctrl.latchMode = latchEn;
    // a clear only means something while the flag is in use
    ctrl.clrStrobe = latchEn & latchClr;
    ctrl.clkPick   = filtClkSel;
  end
endmodule

// File: rtl/wake_req_datapath.sv
module wake_req_datapath
  import wake_req_pkg::*;
#(
  parameter int unsigned Width = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] fabOut,
  input  logic [Width-1:0] intMask,
  input  logic             filtClkLp,
  input  logic             filtClkFast,
  input  logic             filtClkAlt,
  input  wakeCtrlT         ctrl,
  output logic             wakeReq
);
  localparam logic [LenW-1:0] MaxCnt = {LenW{1'b1}};

  logic            rawReq;
  logic            filtClk;
  logic            filtOut;
  logic [LenW-1:0] cnt;
  logic            latchQ;

  // masking and reduction
  assign rawReq = |(fabOut & intMask);

  // filter clock selection, plain mux
  always_comb begin
    unique case (ctrl.clkPick)
      2'd0:    filtClk = filtClkLp;
      2'd1:    filtClk = filtClkFast;
      default: filtClk = filtClkAlt;
    endcase
  end

  // glitch filter: change level after filtLen consecutive disagreeing samples
  always_ff @(posedge filtClk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      cnt     <= '0;
    end else if (ctrl.bypass) begin
      filtOut <= rawReq;
      cnt     <= '0;
    end else if (rawReq != filtOut) begin
      if ({1'b0, cnt} + 3'd1 >= {1'b0, ctrl.filtLen}) begin
        filtOut <= rawReq;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // sticky flag on the fabric clock, fed by the unfiltered raw request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (!ctrl.latchMode) begin
      latchQ <= 1'b0;
    end else begin
      latchQ <= rawReq | (latchQ & ~ctrl.clrStrobe);
    end
  end

  always_comb begin
    if (ctrl.latchMode)   wakeReq = latchQ;
    else if (ctrl.bypass) wakeReq = rawReq;
    else                  wakeReq = filtOut;
  end

  // R4: a sample agreeing with the output never moves it
  a_r4_agree_holds: assert property (@(posedge filtClk) disable iff (!rstN)
    (!ctrl.bypass && rawReq == filtOut) |=> $stable(filtOut));

  // R4: the run counter stays below the longest filter length
  a_r4_cnt_bound: assert property (@(posedge filtClk) disable iff (!rstN)
    cnt != MaxCnt);

  // R6: a set flag stays set without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.latchMode && latchQ && !ctrl.clrStrobe) |=> latchQ);

  // R7 / R8: raw high at an edge sets the flag, clear or not, filter or not
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.latchMode && rawReq) |=> latchQ);

  // R9: outside latch mode the flag is emptied on the next edge
  a_r9_flag_empty: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.latchMode |=> !latchQ);
endmodule

// File: rtl/wake_req_gen.sv
module wake_req_gen
  import wake_req_pkg::*;
#(
  parameter int unsigned Width = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] fabOut,
  input  logic [Width-1:0] intMask,
  input  logic [1:0]       filtMode,
  input  logic [1:0]       filtClkSel,
  input  logic             filtClkLp,
  input  logic             filtClkFast,
  input  logic             filtClkAlt,
  input  logic             latchEn,
  input  logic             latchClr,
  output logic             wakeReq
);
  wakeCtrlT ctrl;

  wake_req_ctrl u_ctrl (
    .filtMode   (filtMode),
    .filtClkSel (filtClkSel),
    .latchEn    (latchEn),
    .latchClr   (latchClr),
    .ctrl       (ctrl)
  );

  wake_req_datapath #(.Width(Width)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fabOut      (fabOut),
    .intMask     (intMask),
    .filtClkLp   (filtClkLp),
    .filtClkFast (filtClkFast),
    .filtClkAlt  (filtClkAlt),
    .ctrl        (ctrl),
    .wakeReq     (wakeReq)
  );
endmodule

// File: tb/wake_req_gen_bench.sv
`timescale 1ns/1ps
module wake_req_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] fabOut = '0;
  logic [7:0] intMask = '0;
  logic [1:0] filtMode = '0;
  logic [1:0] filtClkSel = '0;
  logic       filtClkLp = 1'b0;
  logic       filtClkFast = 1'b0;
  logic       filtClkAlt = 1'b0;
  logic       latchEn = 1'b0;
  logic       latchClr = 1'b0;
  logic       wakeReq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  wake_req_gen u_wake_req_gen (
    .clk(clk), .rstN(rstN), .fabOut(fabOut), .intMask(intMask),
    .filtMode(filtMode), .filtClkSel(filtClkSel),
    .filtClkLp(filtClkLp), .filtClkFast(filtClkFast), .filtClkAlt(filtClkAlt),
    .latchEn(latchEn), .latchClr(latchClr), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic exp);
    nChecks++;
    if (wakeReq !== exp) begin
      nFails++;
      $display("FAIL %s: wakeReq=%b expected %b", req, wakeReq, exp);
    end
  endtask

  // one pulse on a filter clock: 0 lp, 1 fast, 2 alt
  task automatic pulse(input int which);
    #1;
    case (which)
      0: filtClkLp = 1'b1;
      1: filtClkFast = 1'b1;
      default: filtClkAlt = 1'b1;
    endcase
    #2;
    filtClkLp = 1'b0; filtClkFast = 1'b0; filtClkAlt = 1'b0;
    #2;
  endtask

  task automatic clkEdge();
    @(posedge clk); #1;
  endtask

  task automatic setIn(input logic [7:0] f);
    @(negedge clk); fabOut = f;
  endtask

  task automatic testReset();
    check("R2 reset", 1'b0);
  endtask

  task automatic testMask();
    filtMode = 0; latchEn = 0;
    intMask = 8'h00; fabOut = 8'hFF; #1; check("R1 none enabled", 1'b0);
    intMask = 8'h10; fabOut = 8'h10; #1; check("R3 bypass one bit", 1'b1);
    fabOut = 8'hEF; #1; check("R1 complement", 1'b0);
    intMask = 8'hFF; fabOut = 8'h80; #1; check("R1 all enabled", 1'b1);
    fabOut = 8'h00; #1; check("R3 bypass low", 1'b0);
  endtask

  // settle filter output to 0 via bypass on clock `which`
  task automatic primeFilter(input int which, input logic [1:0] sel);
    filtClkSel = sel; filtMode = 0; fabOut = 8'h00;
    pulse(which);
  endtask

  task automatic testFilter2();
    intMask = 8'h01;
    primeFilter(1, 2'd1);
    filtMode = 2;
    fabOut = 8'h01;
    pulse(1); check("R4 n2 after one", 1'b0);
    pulse(0); pulse(2); check("R5 unselected clocks", 1'b0);
    pulse(1); check("R4 n2 after two", 1'b1);
    fabOut = 8'h00; pulse(1); check("R4 n2 fall one", 1'b1);
    fabOut = 8'h01; pulse(1); check("R4 glitch restart", 1'b1);
    fabOut = 8'h00; pulse(1); check("R4 restarted one", 1'b1);
    pulse(1); check("R4 n2 fall two", 1'b0);
  endtask

  task automatic testFilter3();
    primeFilter(2, 2'd2);
    filtMode = 3; fabOut = 8'h01;
    pulse(2); pulse(2); check("R4 n3 after two", 1'b0);
    pulse(1); check("R5 fast ignored on sel2", 1'b0);
    pulse(2); check("R4 n3 after three", 1'b1);
  endtask

  task automatic testFilter1();
    primeFilter(0, 2'd0);
    filtMode = 1; fabOut = 8'h01;
    #1; check("R4 n1 before edge", 1'b0);
    pulse(2); check("R5 alt ignored on sel0", 1'b0);
    pulse(0); check("R4 n1 one edge", 1'b1);
    fabOut = 8'h00;
  endtask

  task automatic testLatch();
    @(negedge clk);
    filtMode = 0; latchEn = 1; fabOut = 8'h00; intMask = 8'h01;
    clkEdge(); check("R6 flag empty", 1'b0);
    setIn(8'h01); clkEdge(); check("R6 set", 1'b1);
    setIn(8'h00); clkEdge(); check("R6 stays", 1'b1);
    clkEdge(); check("R6 stays two", 1'b1);
    @(negedge clk); latchClr = 1; clkEdge(); check("R7 clear", 1'b0);
    @(negedge clk); fabOut = 8'h01; clkEdge(); check("R7 clear vs set", 1'b1);
    @(negedge clk); latchClr = 0; fabOut = 8'h00;
  endtask

  task automatic testLatchFiltered();
    @(negedge clk); latchClr = 1; clkEdge(); check("R7 cleared", 1'b0);
    @(negedge clk); latchClr = 0; filtMode = 3; fabOut = 8'h01;
    clkEdge(); check("R8 set unfiltered", 1'b1);
    setIn(8'h00); clkEdge(); check("R8 stays", 1'b1);
  endtask

  task automatic testNoSticky();
    @(negedge clk); latchEn = 0; filtMode = 0; fabOut = 8'h00;
    #1; check("R9 follows low", 1'b0);
    fabOut = 8'h01; #1; check("R9 follows high", 1'b1);
    fabOut = 8'h00; #1; check("R9 no stick", 1'b0);
    clkEdge();
    @(negedge clk); latchEn = 1; #1; check("R9 flag emptied", 1'b0);
    @(negedge clk); latchEn = 0;
  endtask

  initial begin
    #20; rstN = 1'b1; #5;
    testReset();
    testMask();
    testFilter2();
    testFilter3();
    testFilter1();
    testLatch();
    testLatchFiltered();
    testNoSticky();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule